// File: doc/BRIEF.md
# Reciprocal-Root Optimizer Step Unit

This block produces the per-weight update step of an adaptive-moment optimizer without a divider. It takes the signed first moment and the unsigned root of the second moment, both as Q16.16 fixed-point words. It returns the first moment divided by that root, scaled down by a fixed power of two. The division becomes a multiplication by an approximate reciprocal of the root.

The reciprocal is built in three steps. The root, with one LSB added, is normalised into a single-precision bit pattern using a leading-one search. That pattern, read as an unsigned integer, is subtracted from a magic constant, which gives a first estimate as a float pattern. The estimate is converted back to Q16.16 and refined by one Newton iteration. All of the arithmetic after the subtraction stays in fixed point.

The block is a five-stage pipeline with a valid bit. It accepts one operand pair on every cycle, and its result does not depend on any earlier operand.

Top module: `magic_recip_step`

## Requirements
- R1: A result appears with `outValid` high exactly 5 clock cycles after the operands are presented with `inValid` high, one result per accepted input, in order, back to back. `outValid` is never high without a matching input.
- R2: While `rstN` is low, and after reset, `outValid` and `stepOut` are 0.
- R3: The root operand is incremented by one LSB (0x00000001), saturating at 0xFFFFFFFF, before any use. A zero root therefore gives a defined result: with a moment of +1.0 (0x00010000) the step is 0x1FFFFFFF, and with -1.0 it is 0xE0000001.
- R4: Fixed-to-float conversion truncates. If bit p is the highest set bit of the adjusted root, the pattern has sign 0, biased exponent p+111 (bias 127 less 16 fraction bits), and a mantissa made of the 23 bits below bit p, truncated or zero-filled.
- R5: The first estimate pattern is 0x7EF477D3 minus the converted pattern, as unsigned 32-bit integers.
- R6: Float-to-fixed conversion of the estimate takes the 24-bit significand (implicit one included) shifted by exponent-134 places. It saturates to 0x7FFFFFFF when the left shift exceeds 7. Right shifts truncate, and a shift of 24 or more places gives 0. An all-ones root therefore yields a zero step.
- R7: Newton refinement: t = (y1·v)>>16, c = (y1·t)>>16, y2 = 2·y1 − c. Products are 64 bits wide and keep bits 47..16. y2 is clamped to the range 0 to 0x7FFFFFFF. A root operand of 0x0000FFFF with moment 0x00010000 gives 0x00003FDE.
- R8: The step magnitude is (|m|·y2)>>18, saturated at 0x7FFFFFFF, and the step takes the sign of the moment by two's-complement negation. A zero moment gives 0. A moment of 0x80000000 with a zero root gives 0x80000001.
- R9: The bias-correction scale is a fixed right shift that does not depend on how many updates came before. Identical operands always give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair present this cycle |
| momentIn | input | 32 | First moment, signed Q16.16 |
| rootVarIn | input | 32 | Root of second moment, unsigned Q16.16 |
| outValid | output | 1 | Step result present this cycle |
| stepOut | output | 32 | Update step, signed Q16.16 |

## Verification
The bench builds the block with its default parameters: 16 fraction bits, a scale shift of 2, an epsilon of one LSB and the 0x7EF477D3 constant. With that epsilon, a zero root drives the first estimate into its saturation clamp. An all-ones root drives the estimate below the fixed-point range, so it flushes to zero. Pairing the most negative moment with a zero root reaches the output clamp and the negation. Random root values are spread over all magnitudes, so every exponent the converters can produce is visited in back-to-back and gapped streams.

// File: rtl/recip_step_pkg.sv
package recip_step_pkg;

  localparam int WORD_W   = 32;
  localparam int MANT_W   = 23;
  localparam int EXP_BIAS = 127;
  localparam int SIG_W    = MANT_W + 1;
  localparam int STAGES   = 5;

  typedef struct packed {
    logic [STAGES-1:0] load;
  } stage_ctrl_t;

  function automatic int highBit(input logic [WORD_W-1:0] x);
    int idx;
    idx = 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (x[i]) idx = i;
    end
    return idx;
  endfunction

  function automatic logic [WORD_W-1:0] mulTrunc(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input int fracBits);
    return WORD_W'(({{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b}) >> fracBits);
  endfunction

endpackage

// File: rtl/recip_fix2flt.sv
module recip_fix2flt
  import recip_step_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic [WORD_W-1:0] fixIn,
  output logic [WORD_W-1:0] fltOut
);

  always_comb begin
    int topBit;
    logic [MANT_W-1:0] mant;
    logic [7:0] expo;
    topBit = highBit(fixIn);
    expo   = 8'(topBit + EXP_BIAS - FRAC_W);
    if (topBit >= MANT_W)
      mant = MANT_W'(fixIn >> (topBit - MANT_W));
    else
      mant = MANT_W'(fixIn << (MANT_W - topBit));
    fltOut = {1'b0, expo, mant};
  end

endmodule

// File: rtl/recip_flt2fix.sv
module recip_flt2fix
  import recip_step_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic [WORD_W-1:0] fltIn,
  output logic [WORD_W-1:0] fixOut
);

  localparam int SHIFT_ZERO = EXP_BIAS + MANT_W - FRAC_W;
  localparam int MAX_LEFT   = WORD_W - 1 - SIG_W;
  localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};

  always_comb begin
    int sh;
    logic [WORD_W-1:0] sigWide;
    sigWide = WORD_W'({1'b1, fltIn[MANT_W-1:0]});
    sh      = int'(fltIn[WORD_W-2:MANT_W]) - SHIFT_ZERO;
    if (fltIn[WORD_W-1])
      fixOut = '0;
    else if (sh > MAX_LEFT)
      fixOut = POS_MAX;
    else if (sh >= 0)
      fixOut = sigWide << sh;
    else if (sh <= -SIG_W)
      fixOut = '0;
    else
      fixOut = sigWide >> (-sh);
  end

endmodule

// File: rtl/recip_step_ctrl.sv
module recip_step_ctrl
  import recip_step_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output stage_ctrl_t ctrl,
  output logic        outValid
);

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  assign ctrl.load = {validPipe[STAGES-2:0], inValid};
  assign outValid  = validPipe[STAGES-1];

endmodule

// File: rtl/recip_step_dp.sv
module recip_step_dp
  import recip_step_pkg::*;
#(
  parameter int              FRAC_W      = 16,
  parameter int              SCALE_SHIFT = 2,
  parameter int              EPS         = 1,
  parameter logic [WORD_W-1:0] MAGIC     = 32'h7EF477D3
) (
  input  logic              clk,
  input  logic              rstN,
  input  stage_ctrl_t       ctrl,
  input  logic [WORD_W-1:0] momentIn,
  input  logic [WORD_W-1:0] rootVarIn,
  output logic [WORD_W-1:0] stepOut
);

  localparam logic [WORD_W-1:0] POS_MAX   = {1'b0, {(WORD_W-1){1'b1}}};
  localparam int                OUT_SHIFT = FRAC_W + SCALE_SHIFT;

  // stage 1: epsilon and fixed-to-float
  logic [WORD_W:0]   vSum;
  logic [WORD_W-1:0] vEps, fltBits;
  logic [WORD_W-1:0] s1Flt, s1V, s1M;

  assign vSum = {1'b0, rootVarIn} + (WORD_W+1)'(EPS);
  assign vEps = vSum[WORD_W] ? '1 : vSum[WORD_W-1:0];

  recip_fix2flt #(.FRAC_W(FRAC_W)) i_fix2flt (.fixIn(vEps), .fltOut(fltBits));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Flt <= '0; s1V <= '0; s1M <= '0;
    end else if (ctrl.load[0]) begin
      s1Flt <= fltBits; s1V <= vEps; s1M <= momentIn;
    end
  end

  // stage 2: magic subtraction and float-to-fixed
  logic [WORD_W-1:0] estBits, y1Fix;
  logic [WORD_W-1:0] s2Y1, s2V, s2M;

  assign estBits = MAGIC - s1Flt;

  recip_flt2fix #(.FRAC_W(FRAC_W)) i_flt2fix (.fltIn(estBits), .fixOut(y1Fix));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Y1 <= '0; s2V <= '0; s2M <= '0;
    end else if (ctrl.load[1]) begin
      s2Y1 <= y1Fix; s2V <= s1V; s2M <= s1M;
    end
  end

  // stage 3: y1 * v
  logic [WORD_W-1:0] s3T, s3Y1, s3M;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s3T <= '0; s3Y1 <= '0; s3M <= '0;
    end else if (ctrl.load[2]) begin
      s3T  <= mulTrunc(s2Y1, s2V, FRAC_W);
      s3Y1 <= s2Y1;
      s3M  <= s2M;
    end
  end

  // stage 4: Newton correction
  logic [WORD_W-1:0] corr, y2Next;
  logic [WORD_W+1:0] diff;
  logic [WORD_W-1:0] s4Y2, s4M;

  assign corr = mulTrunc(s3Y1, s3T, FRAC_W);
  assign diff = {1'b0, s3Y1, 1'b0} - {2'b00, corr};

  always_comb begin
    if (diff[WORD_W+1])
      y2Next = '0;
    else if (diff[WORD_W:WORD_W-1] != 2'b00)
      y2Next = POS_MAX;
    else
      y2Next = diff[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s4Y2 <= '0; s4M <= '0;
    end else if (ctrl.load[3]) begin
      s4Y2 <= y2Next; s4M <= s4MNext;
    end
  end

  logic [WORD_W-1:0] s4MNext;
  assign s4MNext = s3M;

  // stage 5: moment multiply, scale and sign
  logic [WORD_W-1:0]   momMag, stepMag, stepNext;
  logic [2*WORD_W-1:0] scaled;

  assign momMag = s4M[WORD_W-1] ? (~s4M + 1'b1) : s4M;
  assign scaled = ({{WORD_W{1'b0}}, momMag} * {{WORD_W{1'b0}}, s4Y2}) >> OUT_SHIFT;
  assign stepMag = (scaled > (2*WORD_W)'(POS_MAX)) ? POS_MAX : scaled[WORD_W-1:0];
  assign stepNext = s4M[WORD_W-1] ? (~stepMag + 1'b1) : stepMag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stepOut <= '0;
    else if (ctrl.load[4])  stepOut <= stepNext;
  end

endmodule

// File: rtl/magic_recip_step.sv
module magic_recip_step
  import recip_step_pkg::*;
#(
  parameter int              FRAC_W      = 16,
  parameter int              SCALE_SHIFT = 2,
  parameter int              EPS         = 1,
  parameter logic [31:0]     MAGIC       = 32'h7EF477D3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] momentIn,
  input  logic [31:0] rootVarIn,
  output logic        outValid,
  output logic [31:0] stepOut
);

  stage_ctrl_t ctrl;

  recip_step_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .ctrl(ctrl), .outValid(outValid)
  );

  recip_step_dp #(
    .FRAC_W(FRAC_W), .SCALE_SHIFT(SCALE_SHIFT), .EPS(EPS), .MAGIC(MAGIC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .momentIn(momentIn), .rootVarIn(rootVarIn), .stepOut(stepOut)
  );

endmodule

// File: rtl/magic_recip_step_chk.sv
module magic_recip_step_chk
  import recip_step_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] momentIn,
  input logic [31:0] rootVarIn,
  input logic        outValid,
  input logic [31:0] stepOut
);

  logic [2:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       sinceRst <= '0;
    else if (sinceRst != 3'(STAGES)) sinceRst <= sinceRst + 3'd1;
  end

  assign warm = (sinceRst == 3'(STAGES));

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (outValid == $past(inValid, STAGES)));  // R1

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (!outValid && stepOut == 32'd0));  // R2

  AST_STEP_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && stepOut != 32'd0) |-> (stepOut[31] == $past(momentIn[31], STAGES)));  // R8

  AST_ZERO_MOMENT: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && $past(momentIn, STAGES) == 32'd0) |-> (stepOut == 32'd0));  // R8

  AST_ALLONES_ROOT: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && $past(rootVarIn, STAGES) == 32'hFFFFFFFF) |-> (stepOut == 32'd0));  // R6

  AST_NO_MIN_WORD: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (stepOut != 32'h80000000));  // R8

endmodule

bind magic_recip_step magic_recip_step_chk i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .momentIn(momentIn),
  .rootVarIn(rootVarIn), .outValid(outValid), .stepOut(stepOut)
);

// File: tb/test_magic_recip_step.sv
module test_magic_recip_step;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] momentIn = '0;
  logic [31:0] rootVarIn = '0;
  logic        outValid;
  logic [31:0] stepOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic done = 1'b0;

  typedef struct {
    logic [31:0] expStep;
    int          dueCyc;
    string       tag;
  } exp_item_t;

  exp_item_t expQ[$];

  magic_recip_step i_magic_recip_step (
    .clk(clk), .rstN(rstN), .inValid(inValid), .momentIn(momentIn),
    .rootVarIn(rootVarIn), .outValid(outValid), .stepOut(stepOut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference from the requirement text
  function automatic logic [31:0] refStep(input logic [31:0] m, input logic [31:0] r);
    logic [31:0] v, flt, est, y1, t, c, y2, mag, res;
    logic [63:0] p;
    logic [33:0] d;
    int top, sh;
    v = (r == 32'hFFFFFFFF) ? r : r + 32'd1;                        // R3
    top = 0;
    for (int i = 0; i < 32; i++) if (v[i]) top = i;
    flt[31] = 1'b0;                                                 // R4
    flt[30:23] = 8'(top + 111);
    flt[22:0] = (top >= 23) ? 23'(v >> (top - 23)) : 23'(v << (23 - top));
    est = 32'h7EF477D3 - flt;                                       // R5
    sh = int'(est[30:23]) - 134;                                    // R6
    if (sh > 7)         y1 = 32'h7FFFFFFF;
    else if (sh >= 0)   y1 = {8'd0, 1'b1, est[22:0]} << sh;
    else if (sh <= -24) y1 = 32'd0;
    else                y1 = {8'd0, 1'b1, est[22:0]} >> (-sh);
    p = {32'd0, y1} * {32'd0, v}; t = p[47:16];                     // R7
    p = {32'd0, y1} * {32'd0, t}; c = p[47:16];
    d = {1'b0, y1, 1'b0} - {2'b00, c};
    if (d[33])               y2 = 32'd0;
    else if (d[32:31] != 0)  y2 = 32'h7FFFFFFF;
    else                     y2 = d[31:0];
    mag = m[31] ? (~m + 32'd1) : m;                                 // R8
    p = ({32'd0, mag} * {32'd0, y2}) >> 18;
    res = (p > 64'h7FFFFFFF) ? 32'h7FFFFFFF : p[31:0];
    return m[31] ? (~res + 32'd1) : res;
  endfunction

  task automatic sendItem(input logic [31:0] m, input logic [31:0] r, input string tag,
                          input logic useFixed, input logic [31:0] fixedExp);
    exp_item_t it;
    @(negedge clk);
    inValid   = 1'b1;
    momentIn  = m;
    rootVarIn = r;
    it.expStep = useFixed ? fixedExp : refStep(m, r);
    it.dueCyc  = cyc + 5;                                           // R1
    it.tag     = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      momentIn = $urandom;
      rootVarIn = $urandom;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1: outValid high with no pending input, actual step %h expected none", stepOut);
      end else begin
        exp_item_t it;
        it = expQ.pop_front();
        if (stepOut !== it.expStep || cyc != it.dueCyc) begin
          errors++;
          $display("FAIL %s: step %h at cycle %0d, expected %h at cycle %0d",
                   it.tag, stepOut, cyc, it.expStep, it.dueCyc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rr, mm, firstOut;
    repeat (3) @(negedge clk);
    // R2: reset state
    checks++;
    if (outValid !== 1'b0) begin
      errors++; $display("FAIL R2: outValid %b expected 0", outValid);
    end
    checks++;
    if (stepOut !== 32'd0) begin
      errors++; $display("FAIL R2: stepOut %h expected 00000000", stepOut);
    end
    @(negedge clk); rstN = 1'b1;
    idle(3);

    // R7 known point, R8 sign
    sendItem(32'h00010000, 32'h0000FFFF, "R7", 1'b1, 32'h00003FDE);
    sendItem(32'hFFFF0000, 32'h0000FFFF, "R8", 1'b1, 32'hFFFFC022);
    // R3 zero root with epsilon
    sendItem(32'h00010000, 32'h00000000, "R3", 1'b1, 32'h1FFFFFFF);
    sendItem(32'hFFFF0000, 32'h00000000, "R3", 1'b1, 32'hE0000001);
    // R8 output clamp with most negative moment
    sendItem(32'h80000000, 32'h00000000, "R8", 1'b1, 32'h80000001);
    // R6 all-ones root flushes estimate to zero
    sendItem(32'h7FFFFFFF, 32'hFFFFFFFF, "R6", 1'b1, 32'h00000000);
    // R8 zero moment
    sendItem(32'h00000000, 32'h00012345, "R8", 1'b1, 32'h00000000);
    idle(2);

    // R4 R5: every exponent position of the root
    for (int b = 0; b < 32; b++) begin
      sendItem(32'h00008000, 32'h1 << b, "R4", 1'b0, '0);
      sendItem(32'hFFFFA000, (32'h1 << b) | (32'h1 << (b / 2)), "R5", 1'b0, '0);
    end
    idle(4);

    // R1: back-to-back and gapped random streams
    for (int k = 0; k < 300; k++) begin
      rr = $urandom >> ($urandom % 32);
      mm = $urandom >> ($urandom % 24);
      if ($urandom % 2 == 1) mm = ~mm + 32'd1;
      sendItem(mm, rr, "R1", 1'b0, '0);
      if ($urandom % 4 == 0) idle($urandom % 3 + 1);
    end
    idle(8);

    // R9: same operands after unrelated history give the same step
    sendItem(32'h00023456, 32'h0003ABCD, "R9", 1'b0, '0);
    for (int k = 0; k < 20; k++) sendItem($urandom, $urandom, "R9", 1'b0, '0);
    idle(2);
    sendItem(32'h00023456, 32'h0003ABCD, "R9", 1'b0, '0);
    idle(1);
    firstOut = refStep(32'h00023456, 32'h0003ABCD);
    idle(10);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing, expected 0 (last ref %h)", expQ.size(), firstOut);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule